// File: doc/BRIEF.md
# UART Receive FIFO Controller

This block buffers received characters for a 16550-class serial port. A deserializer hands it one byte at a time with a valid strobe. The host takes bytes out with read strobes of the receive buffer. A write to the FIFO-control register sets the operating mode. In FIFO mode, up to sixteen bytes are held in arrival order. In non-FIFO mode, a single holding register is used instead, and each new byte overwrites the previous one.

The block also decodes the receive trigger threshold that interrupt logic compares against the fill count. It runs an inactivity timer four character times long, so that a few bytes sitting below the threshold are not left stranded. The length of one character time is given as a cycle count input. Interrupt prioritisation and the bit-level receiver sit outside this block.

Top module: `uart_rx_fifo_ctl`

## Requirements
- R1: In FIFO mode (control bit 0 set), up to 16 bytes are held and read out first-in first-out. `fill_count` gives the number held, 0 to 16, and `data_ready` is high exactly when that count is non-zero. In non-FIFO mode `fill_count` reads 0.
- R2: A byte that arrives while the FIFO holds 16 bytes, with no read in the same cycle, is dropped. The stored bytes and their order are unchanged, and `overrun` is set.
- R3: Control bits 7:6 select the trigger threshold shown on `trig_level`: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14.
- R4: A control write is ignored entirely when its value equals the stored value. Only bits 7, 6, 3 and 0 are stored. Otherwise, bit 1 flushes the receive FIFO, and bit 2 raises `tx_flush` for that cycle.
- R5: A control write that changes bit 0 forces both the receive flush and `tx_flush`, whatever the state of bits 1 and 2.
- R6: A receive flush empties the FIFO, clears `data_ready`, stops the timeout timer and clears `timeout_pend`.
- R7: Each byte received in FIFO mode, and each read that leaves the FIFO non-empty, restarts a timer of 4×`char_cycles` cycles. When the timer expires, `timeout_pend` is set only if the FIFO is non-empty at that moment.
- R8: A receive buffer read in FIFO mode clears `timeout_pend`.
- R9: In non-FIFO mode, a byte arriving while `data_ready` is high replaces the held byte and sets `overrun`. A read returns the held byte and clears `data_ready`.
- R10: A read returns its byte on `rd_data` one cycle after the strobe. A read of an empty FIFO returns 0x00 and leaves the count at 0.
- R11: `overrun` stays set until a `status_rd` strobe clears it. A new overrun in the same cycle as that strobe takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rd_strobe | input | 1 | Host read of the receive buffer |
| status_rd | input | 1 | Host read of line status; clears overrun |
| fcr_wr | input | 1 | FIFO-control register write strobe |
| fcr_data | input | 8 | FIFO-control write value |
| char_cycles | input | CT_W | Clock cycles per character time |
| rd_data | output | 8 | Byte returned by the last read |
| data_ready | output | 1 | Receive data available |
| overrun | output | 1 | Sticky overrun flag |
| fill_count | output | CW | Bytes held in the FIFO |
| trig_level | output | CW | Active trigger threshold |
| timeout_pend | output | 1 | Character timeout pending |
| tx_flush | output | 1 | One-cycle transmit FIFO reset request |

## Verification
Pointer or count corruption surfaces within one read. Either `rd_data` returns bytes out of arrival order, or `fill_count` and `data_ready` disagree with the number of bytes pushed, on the cycle after the faulty update. A timer that reloads at the wrong moment shows up on `timeout_pend`, one cycle early or late, against the exact expiry cycle the bench computes from `char_cycles`. A wrongly decoded control write shows up in the same cycle on `tx_flush`, or one cycle later on the count and trigger outputs.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam logic [7:0] FCR_STORE_MASK = 8'hC9;
  localparam int FCR_EN_BIT    = 0;
  localparam int FCR_RXCLR_BIT = 1;
  localparam int FCR_TXCLR_BIT = 2;

  function automatic int unsigned trig_of(input logic [1:0] code);
    case (code)
      2'b00:   trig_of = 1;
      2'b01:   trig_of = 4;
      2'b10:   trig_of = 8;
      default: trig_of = 14;
    endcase
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          drop
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q, wr_n, rd_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    bump = (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    do_pop  = pop && (cnt_q != '0);
    do_push = push && ((cnt_q != CW'(DEPTH)) || do_pop);
    drop    = push && !do_push;
    wr_n    = wr_q;
    rd_n    = rd_q;
    cnt_n   = cnt_q;
    if (clr) begin
      wr_n  = '0;
      rd_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_push) wr_n = bump(wr_q);
      if (do_pop)  rd_n = bump(rd_q);
      if (do_push && !do_pop)      cnt_n = cnt_q + CW'(1);
      else if (do_pop && !do_push) cnt_n = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_q] <= din;
  end

  assign head  = mem[rd_q];
  assign count = cnt_q;

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  p_full_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !clr && cnt_q == CW'(DEPTH)) |=> (head == $past(head) && cnt_q == CW'(DEPTH)));
endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
  parameter int CT_W = 12,
  localparam int TW  = CT_W + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            load,
  input  logic            ack,
  input  logic            has_data,
  input  logic [CT_W-1:0] char_cycles,
  output logic            pend
);
  logic [TW-1:0] cnt_q, cnt_n;
  logic          pend_q, pend_n, expire;

  always_comb begin
    expire = (cnt_q == TW'(1));
    cnt_n  = cnt_q;
    pend_n = pend_q;
    if (clr) begin
      cnt_n  = '0;
      pend_n = 1'b0;
    end else begin
      if (load)                cnt_n = {char_cycles, 2'b00};
      else if (cnt_q != '0)    cnt_n = cnt_q - TW'(1);
      if (ack)                           pend_n = 1'b0;
      else if (expire && !load && has_data) pend_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      pend_q <= pend_n;
    end
  end

  assign pend = pend_q;

  p_flush_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pend);

  p_pend_needs_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(has_data));

  p_read_acks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !pend);
endmodule

// File: rtl/uart_rx_fifo_ctl.sv
module uart_rx_fifo_ctl #(
  parameter int DEPTH = 16,
  parameter int CT_W  = 12,
  localparam int W    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_valid,
  input  logic [W-1:0]    rx_byte,
  input  logic            rd_strobe,
  input  logic            status_rd,
  input  logic            fcr_wr,
  input  logic [7:0]      fcr_data,
  input  logic [CT_W-1:0] char_cycles,
  output logic [W-1:0]    rd_data,
  output logic            data_ready,
  output logic            overrun,
  output logic [CW-1:0]   fill_count,
  output logic [CW-1:0]   trig_level,
  output logic            timeout_pend,
  output logic            tx_flush
);
  import rxq_pkg::*;

  logic [7:0]   fcr_q, fcr_n;
  logic [W-1:0] hold_q, hold_n, rd_q, rd_n;
  logic         dr_q, dr_n, ovr_q, ovr_n;
  logic         fifo_en, fcr_take, en_flip, rx_flush;
  logic         st_push, st_pop, st_drop, tm_load;
  logic [W-1:0] st_head;
  logic [CW-1:0] st_count;

  always_comb begin
    fifo_en  = fcr_q[FCR_EN_BIT];
    fcr_take = fcr_wr && (fcr_data != fcr_q);
    en_flip  = fcr_take && (fcr_data[FCR_EN_BIT] != fcr_q[FCR_EN_BIT]);
    rx_flush = fcr_take && (fcr_data[FCR_RXCLR_BIT] || en_flip);
    tx_flush = fcr_take && (fcr_data[FCR_TXCLR_BIT] || en_flip);
    st_push  = fifo_en && rx_valid && !rx_flush;
    st_pop   = fifo_en && rd_strobe && !rx_flush;
    tm_load  = st_push || (st_pop && st_count > CW'(1));
  end

  rxq_store #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(rx_flush), .push(st_push), .pop(st_pop),
    .din(rx_byte), .head(st_head), .count(st_count), .drop(st_drop)
  );

  rxq_timer #(.CT_W(CT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(rx_flush), .load(tm_load), .ack(st_pop),
    .has_data(st_count != '0), .char_cycles(char_cycles), .pend(timeout_pend)
  );

  always_comb begin
    fcr_n  = fcr_take ? (fcr_data & FCR_STORE_MASK) : fcr_q;
    hold_n = hold_q;
    dr_n   = dr_q;
    rd_n   = rd_q;
    ovr_n  = ovr_q;
    if (rx_flush) begin
      dr_n = 1'b0;
    end else if (!fifo_en) begin
      if (rx_valid) begin
        hold_n = rx_byte;
        dr_n   = 1'b1;
      end else if (rd_strobe) begin
        dr_n = 1'b0;
      end
    end
    if (rd_strobe && !rx_flush) begin
      if (fifo_en) rd_n = (st_count != '0) ? st_head : '0;
      else         rd_n = hold_q;
    end
    if (status_rd) ovr_n = 1'b0;
    if (st_drop || (!fifo_en && !rx_flush && rx_valid && dr_q && !rd_strobe))
      ovr_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcr_q  <= '0;
      hold_q <= '0;
      dr_q   <= 1'b0;
      rd_q   <= '0;
      ovr_q  <= 1'b0;
    end else begin
      fcr_q  <= fcr_n;
      hold_q <= hold_n;
      dr_q   <= dr_n;
      rd_q   <= rd_n;
      ovr_q  <= ovr_n;
    end
  end

  assign rd_data    = rd_q;
  assign overrun    = ovr_q;
  assign fill_count = st_count;
  assign data_ready = fifo_en ? (st_count != '0) : dr_q;
  assign trig_level = CW'(trig_of(fcr_q[7:6]));

  p_same_fcr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_wr && fcr_data == fcr_q && !rx_valid && !rd_strobe) |=> $stable(fill_count));

  p_en_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_wr && fcr_data[FCR_EN_BIT] != fcr_q[FCR_EN_BIT]) |-> tx_flush);

  p_en_flip_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_wr && fcr_data[FCR_EN_BIT] != fcr_q[FCR_EN_BIT]) |=> (fill_count == '0 && !timeout_pend));

  p_nonfifo_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !fcr_wr && rx_valid && dr_q && !rd_strobe) |=> overrun);

  p_empty_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && !fcr_wr && rd_strobe && fill_count == '0) |=> (rd_data == '0));
endmodule

// File: tb/uart_rx_fifo_ctl_tb.sv
module uart_rx_fifo_ctl_tb;
  localparam int CW = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_valid, rd_strobe, status_rd, fcr_wr;
  logic [7:0] rx_byte, fcr_data;
  logic [11:0] char_cycles;
  logic [7:0] rd_data;
  logic       data_ready, overrun, timeout_pend, tx_flush;
  logic [CW-1:0] fill_count, trig_level;
  logic       txf_seen;
  int         n_chk = 0;
  int         n_fail = 0;

  always #2 clk = ~clk;

  uart_rx_fifo_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rd_strobe(rd_strobe), .status_rd(status_rd), .fcr_wr(fcr_wr),
    .fcr_data(fcr_data), .char_cycles(char_cycles), .rd_data(rd_data),
    .data_ready(data_ready), .overrun(overrun), .fill_count(fill_count),
    .trig_level(trig_level), .timeout_pend(timeout_pend), .tx_flush(tx_flush)
  );

  // op[23:22] 0=push 1=read 2=control write; data[21:14]; count[13:9]; ready[8]; rd[7:0]
  localparam logic [23:0] VEC [16] = '{
    {2'd2, 8'h01, 5'd0, 1'b0, 8'h00},
    {2'd0, 8'hA1, 5'd1, 1'b1, 8'h00},
    {2'd0, 8'hB2, 5'd2, 1'b1, 8'h00},
    {2'd0, 8'hC3, 5'd3, 1'b1, 8'h00},
    {2'd1, 8'h00, 5'd2, 1'b1, 8'hA1},
    {2'd0, 8'hD4, 5'd3, 1'b1, 8'h00},
    {2'd1, 8'h00, 5'd2, 1'b1, 8'hB2},
    {2'd1, 8'h00, 5'd1, 1'b1, 8'hC3},
    {2'd1, 8'h00, 5'd0, 1'b0, 8'hD4},
    {2'd1, 8'h00, 5'd0, 1'b0, 8'h00},
    {2'd0, 8'h5A, 5'd1, 1'b1, 8'h00},
    {2'd2, 8'h03, 5'd0, 1'b0, 8'h00},
    {2'd0, 8'h77, 5'd1, 1'b1, 8'h00},
    {2'd2, 8'h00, 5'd0, 1'b0, 8'h00},
    {2'd0, 8'h99, 5'd0, 1'b1, 8'h00},
    {2'd1, 8'h00, 5'd0, 1'b0, 8'h99}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
  endtask

  task automatic stat_read();
    @(negedge clk); status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
  endtask

  task automatic fcr(input logic [7:0] v);
    @(negedge clk); fcr_wr = 1'b1; fcr_data = v;
    #1 txf_seen = tx_flush;
    @(negedge clk); fcr_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rx_valid = 0; rd_strobe = 0; status_rd = 0; fcr_wr = 0;
    rx_byte = 0; fcr_data = 0; char_cycles = 12'd5; txf_seen = 0;
    do_reset();

    // reset state
    check("R1 reset count", fill_count, 0);
    check("R1 reset ready", data_ready, 0);
    check("R11 reset overrun", overrun, 0);
    check("R7 reset pend", timeout_pend, 0);
    check("R3 reset trig", trig_level, 1);
    check("R10 reset rd_data", rd_data, 0);

    // table walk: R1 ordering, R10 empty read, R6 flush, R5 disable, R9 holding
    for (int i = 0; i < 16; i++) begin
      logic [23:0] v;
      v = VEC[i];
      case (v[23:22])
        2'd0: push(v[21:14]);
        2'd1: pop();
        default: fcr(v[21:14]);
      endcase
      check($sformatf("R1 vec%0d count", i), fill_count, v[13:9]);
      check($sformatf("R1 vec%0d ready", i), data_ready, v[8]);
      if (v[23:22] == 2'd1) check($sformatf("R10 vec%0d rd_data", i), rd_data, v[7:0]);
    end

    // R3 trigger thresholds
    fcr(8'h01); check("R3 trig 00", trig_level, 1);
    fcr(8'h41); check("R3 trig 01", trig_level, 4);
    fcr(8'h81); check("R3 trig 10", trig_level, 8);
    fcr(8'hC1); check("R3 trig 11", trig_level, 14);
    fcr(8'h01);

    // R2 overrun keeps contents
    for (int i = 0; i < 17; i++) push(8'(8'h10 + i));
    check("R2 full count", fill_count, 16);
    check("R2 overrun set", overrun, 1);
    pop();
    check("R2 oldest kept", rd_data, 8'h10);
    for (int i = 0; i < 15; i++) pop();
    check("R2 last stored", rd_data, 8'h1F);
    check("R2 drained", fill_count, 0);
    check("R11 overrun sticky", overrun, 1);
    stat_read();
    check("R11 overrun cleared", overrun, 0);

    // R4 same value ignored, tx reset bit
    push(8'h31); push(8'h32); push(8'h33);
    fcr(8'h01);
    check("R4 same value tx_flush", txf_seen, 0);
    check("R4 same value count", fill_count, 3);
    fcr(8'h05);
    check("R4 tx reset bit", txf_seen, 1);
    check("R4 rx untouched", fill_count, 3);
    // R5 enable toggle
    fcr(8'h00);
    check("R5 toggle tx_flush", txf_seen, 1);
    check("R5 toggle rx flush", fill_count, 0);
    fcr(8'h01);
    check("R5 re-enable tx_flush", txf_seen, 1);

    // R7 timeout: 4*5 = 20 cycles after last restart
    push(8'h41); push(8'h42);
    idle(19); check("R7 not yet expired", timeout_pend, 0);
    idle(1);  check("R7 expired", timeout_pend, 1);
    pop();
    check("R8 read clears pend", timeout_pend, 0);
    check("R8 ready still set", data_ready, 1);
    idle(19); check("R7 reload by read early", timeout_pend, 0);
    idle(1);  check("R7 reload by read expiry", timeout_pend, 1);
    pop();
    check("R8 empty ready", data_ready, 0);
    idle(25); check("R7 empty no pend", timeout_pend, 0);
    push(8'h43); pop();
    idle(25); check("R7 expiry on empty", timeout_pend, 0);

    // R6 flush stops timer and clears pend
    push(8'h51);
    idle(20); check("R6 pend before flush", timeout_pend, 1);
    fcr(8'h03);
    check("R6 flush pend", timeout_pend, 0);
    check("R6 flush count", fill_count, 0);
    check("R6 flush ready", data_ready, 0);

    // R9 non-FIFO overwrite
    fcr(8'h00);
    push(8'h11); push(8'h22);
    check("R9 overrun", overrun, 1);
    check("R9 ready", data_ready, 1);
    stat_read();
    check("R11 clear in holding mode", overrun, 0);
    pop();
    check("R9 newest byte", rd_data, 8'h22);
    check("R9 ready cleared", data_ready, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule